// File: doc/BRIEF.md
# GPI Interrupt Aggregation Controller

This block gathers interrupt requests from a bank of general-purpose input pins and merges them into one active-low interrupt line for a host. Each pin has three settings that software writes over a simple synchronous register port: an interrupt enable, a trigger mode (edge or level) and an active polarity. Every pin first goes through a two-flop synchroniser. An enabled pin that sees its active edge or level sets a pending bit. The pending bits are grouped into 8-bit status registers, and reading one of those registers clears the bits it returned. A separate global status flag records that some pin event was captured. The host clears that flag by writing to it, and status reads leave it alone.

One configuration bit sets how the output behaves. With the bit clear, the interrupt line stays low for as long as any pending bit is set. With the bit set, a status read that leaves other requests pending releases the line for a fixed window of `GAP_CYCLES` clocks and then pulls it low again. The default window is 50 µs, counted at `CLK_HZ`. Edge capture is the reset default, so a pin that is already at its active level before it is enabled produces no interrupt in edge mode. A pin only keeps requesting while it is held active if it is in level mode.

Top module: `gpi_irq_aggregator`

## Requirements
- R1: After reset, irq_n is 1 and every readable register reads 0.
  - Readable registers: configuration, global status, pending, enable, trigger mode and polarity.
  - Address map: address bits [4:2] select the group: 0 = misc, 1 = pending, 2 = enable, 3 = trigger mode, 4 = polarity. Bits [1:0] select the bank, where bank b covers pins 8b..8b+7.
  - In the misc group, bank 0 is the configuration register and bank 1 is the global status register. Any other address reads 0.
- R2: A pin whose enable bit is 0 never sets its pending bit. If the pin was already at its active level when it is enabled in edge mode (trigger-mode bit 0), it produces no pending bit and irq_n stays 1.
- R3: In edge mode, an enabled pin sets its pending bit (bank pin/8, bit pin%8) on its active edge. The active edge is falling when the polarity bit is 0 and rising when it is 1. The opposite edge sets nothing.
- R4: In level mode (trigger-mode bit 1), an enabled pin held at its active level (low for polarity 0, high for polarity 1) sets its pending bit again every clock, so the bit is set again right after a status read.
- R5: A read of pending bank b returns that bank's bits and clears only those bits. Other banks keep their pending bits.
- R6: With configuration bit 4 = 0, irq_n is 0 while any pending bit is set. It stays 0 across a status read that leaves bits pending, and it returns to 1 once all pending bits are clear.
- R7: With configuration bit 4 = 1, a pending read that leaves pending bits set drives irq_n to 1 for exactly GAP_CYCLES clocks, after which it returns to 0.
- R8: If a pending bit is cleared by a read and receives a new event in the same cycle, the event wins and the bit stays set.
- R9: Global status bit 0 becomes 1 when any pin event is captured. Pending reads do not change it. A write with data bit 0 = 1 clears it.
- R10: Enable, trigger-mode and polarity banks read back the byte last written. Only bit 4 of the configuration register is stored. Read data appears on rd_data the cycle after the read request. Writes to pending registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpi_in | input | NUM_BANKS*8 | Asynchronous general-purpose input pins |
| bus_en | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a read request |
| irq_n | output | 1 | Active-low merged interrupt output |

## Verification
The assertions take for granted that the configuration bit is not changed during a release window, and that the pins only change when no request is being captured in the same cycle. The stimulus only rewrites the configuration while irq_n is steady and all pending bits are clear. It holds pins stable for several clocks around each enable change, so each event lands in a known bank and cycle. The back-to-back read of a pin held active in level mode is the only case where a clear and an event meet in the same cycle, and it is set up on purpose for that.

// File: rtl/gpi_irq_pkg.sv
package gpi_irq_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned RETRIG_BIT = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_CFG,
        K_GSTAT,
        K_PEND,
        K_EN,
        K_MODE,
        K_POL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_ASSERT,
        OUT_GAP
    } out_state_e;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nbanks);
        reg_sel_t s;
        s.bank = a[1:0];
        s.kind = K_NONE;
        case (a[4:2])
            3'd0: begin
                if (a[1:0] == 2'd0)      s.kind = K_CFG;
                else if (a[1:0] == 2'd1) s.kind = K_GSTAT;
            end
            3'd1: s.kind = K_PEND;
            3'd2: s.kind = K_EN;
            3'd3: s.kind = K_MODE;
            3'd4: s.kind = K_POL;
            default: s.kind = K_NONE;
        endcase
        if ((s.kind == K_PEND || s.kind == K_EN || s.kind == K_MODE || s.kind == K_POL)
            && (int'(s.bank) >= int'(nbanks)))
            s.kind = K_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpi_sync_detect.sv
module gpi_sync_detect #(
    parameter int unsigned NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins,
    input  logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] act_lvl,
    output logic [NUM_PINS-1:0] act_edge
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pins[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end

        always_comb begin
            act_lvl[i]  = pol[i] ? sync_q[i] : ~sync_q[i];
            act_edge[i] = pol[i] ? (sync_q[i] & ~prev_q[i])
                                 : (~sync_q[i] & prev_q[i]);
        end
    end

endmodule

// File: rtl/gpi_regfile.sv
module gpi_regfile
    import gpi_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    localparam int unsigned NUM_PINS = NUM_BANKS * REG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [NUM_PINS-1:0] ev,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] pend_q,
    output logic [NUM_PINS-1:0] pend_d,
    output logic                retrig_q,
    output logic                pend_rd,
    output logic [REG_W-1:0]    rd_data
);

    reg_sel_t            sel;
    logic                wr;
    logic                rd;
    logic [NUM_PINS-1:0] clr;
    logic                gstat_q;
    logic                gstat_clr;
    logic [REG_W-1:0]    rd_mux;

    always_comb begin
        sel       = decode_addr(bus_addr, NUM_BANKS);
        wr        = bus_en & bus_we;
        rd        = bus_en & ~bus_we;
        pend_rd   = rd && (sel.kind == K_PEND);
        gstat_clr = wr && (sel.kind == K_GSTAT) && bus_wdata[0];
        for (int b = 0; b < NUM_BANKS; b++)
            clr[b*REG_W +: REG_W] = {REG_W{pend_rd && (int'(sel.bank) == b)}};
        pend_d = (pend_q & ~clr) | ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            mode_q   <= '0;
            pol_q    <= '0;
            retrig_q <= 1'b0;
        end else if (wr) begin
            if (sel.kind == K_CFG)
                retrig_q <= bus_wdata[RETRIG_BIT];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(sel.bank) == b) begin
                    if (sel.kind == K_EN)   en_q[b*REG_W +: REG_W]   <= bus_wdata;
                    if (sel.kind == K_MODE) mode_q[b*REG_W +: REG_W] <= bus_wdata;
                    if (sel.kind == K_POL)  pol_q[b*REG_W +: REG_W]  <= bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            gstat_q <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            gstat_q <= (|ev) | (gstat_q & ~gstat_clr);
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            K_CFG:   rd_mux[RETRIG_BIT] = retrig_q;
            K_GSTAT: rd_mux[0] = gstat_q;
            default: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(sel.bank) == b) begin
                        if (sel.kind == K_PEND) rd_mux = pend_q[b*REG_W +: REG_W];
                        if (sel.kind == K_EN)   rd_mux = en_q[b*REG_W +: REG_W];
                        if (sel.kind == K_MODE) rd_mux = mode_q[b*REG_W +: REG_W];
                        if (sel.kind == K_POL)  rd_mux = pol_q[b*REG_W +: REG_W];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_data <= '0;
        else if (rd) rd_data <= rd_mux;
    end

endmodule

// File: rtl/gpi_irq_out.sv
module gpi_irq_out
    import gpi_irq_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 2500,
    localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic retrig,
    input  logic pend_any_q,
    input  logic pend_any_d,
    input  logic pend_rd,
    output logic irq_n,
    output logic in_gap
);

    out_state_e       state_q;
    out_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            OUT_IDLE: begin
                if (pend_any_q) state_d = OUT_ASSERT;
            end
            OUT_ASSERT: begin
                if (pend_rd) begin
                    if (!pend_any_d) begin
                        state_d = OUT_IDLE;
                    end else if (retrig) begin
                        state_d = OUT_GAP;
                        cnt_d   = CNT_W'(GAP_CYCLES - 1);
                    end
                end else if (!pend_any_q) begin
                    state_d = OUT_IDLE;
                end
            end
            OUT_GAP: begin
                if (cnt_q == '0)
                    state_d = pend_any_q ? OUT_ASSERT : OUT_IDLE;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign irq_n  = (state_q != OUT_ASSERT);
    assign in_gap = (state_q == OUT_GAP);

endmodule

// File: rtl/gpi_irq_aggregator.sv
module gpi_irq_aggregator
    import gpi_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 3,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned GAP_CYCLES = (CLK_HZ / 20_000 > 0) ? CLK_HZ / 20_000 : 1,
    localparam int unsigned NUM_PINS  = NUM_BANKS * REG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] gpi_in,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq_n
);

    logic [NUM_PINS-1:0] act_lvl;
    logic [NUM_PINS-1:0] act_edge;
    logic [NUM_PINS-1:0] ev;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] pend_d;
    logic                retrig_q;
    logic                pend_rd;
    logic                in_gap;

    gpi_sync_detect #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pins     (gpi_in),
        .pol      (pol_q),
        .act_lvl  (act_lvl),
        .act_edge (act_edge)
    );

    always_comb ev = en_q & ((mode_q & act_lvl) | (~mode_q & act_edge));

    gpi_regfile #(.NUM_BANKS(NUM_BANKS)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ev        (ev),
        .en_q      (en_q),
        .mode_q    (mode_q),
        .pol_q     (pol_q),
        .pend_q    (pend_q),
        .pend_d    (pend_d),
        .retrig_q  (retrig_q),
        .pend_rd   (pend_rd),
        .rd_data   (rd_data)
    );

    gpi_irq_out #(.GAP_CYCLES(GAP_CYCLES)) out_i (
        .clk        (clk),
        .rst        (rst),
        .retrig     (retrig_q),
        .pend_any_q (|pend_q),
        .pend_any_d (|pend_d),
        .pend_rd    (pend_rd),
        .irq_n      (irq_n),
        .in_gap     (in_gap)
    );

endmodule

// File: rtl/gpi_irq_checker.sv
module gpi_irq_checker #(
    parameter int unsigned NUM_PINS   = 24,
    parameter int unsigned GAP_CYCLES = 2500
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_n,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] en,
    input logic [NUM_PINS-1:0] ev,
    input logic                retrig,
    input logic                in_gap
);

    int unsigned gap_run;

    always_ff @(posedge clk) begin
        if (rst)          gap_run <= 0;
        else if (in_gap)  gap_run <= gap_run + 1;
        else              gap_run <= 0;
    end

    AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(pend) & ~$past(en)) == '0);                          // R2

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        ($past(ev) & ~pend) == '0);                                         // R8

    AST_LOW_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(|pend));                                     // R6

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(retrig) && !$past(irq_n) && (|pend)) |-> !irq_n);           // R6

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_run <= GAP_CYCLES);                                             // R7

    AST_GAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> irq_n);                                                  // R7

endmodule

bind gpi_irq_aggregator gpi_irq_checker #(
    .NUM_PINS   (NUM_PINS),
    .GAP_CYCLES (GAP_CYCLES)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .irq_n  (irq_n),
    .pend   (pend_q),
    .en     (en_q),
    .ev     (ev),
    .retrig (retrig_q),
    .in_gap (in_gap)
);

// File: tb/gpi_irq_aggregator_tb_top.sv
module gpi_irq_aggregator_tb_top;

    localparam int unsigned NB   = 3;
    localparam int unsigned NP   = NB * 8;
    localparam int unsigned GAP  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] gpi_in = '1;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    rd_data;
    logic          irq_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    gpi_irq_aggregator #(.NUM_BANKS(NB), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst(rst), .gpi_in(gpi_in), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic logic [4:0] a_pend(int b); return 5'(4 + b);  endfunction
    function automatic logic [4:0] a_en(int b);   return 5'(8 + b);  endfunction
    function automatic logic [4:0] a_mode(int b); return 5'(12 + b); endfunction
    function automatic logic [4:0] a_pol(int b);  return 5'(16 + b); endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = rd_data;
    endtask

    task automatic bread2(input logic [4:0] a, output logic [7:0] d1, output logic [7:0] d2);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d1 = rd_data;
        @(negedge clk);
        bus_en = 1'b0;
        d2 = rd_data;
    endtask

    task automatic clear_all_pend();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) bread(a_pend(b), d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d2;
        logic [4:0] misc_addr [2];
        int hi;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);

        // R1: reset state
        check("R1 irq_n after reset", int'(irq_n), 1);
        misc_addr[0] = 5'd0; misc_addr[1] = 5'd1;
        for (int k = 0; k < 2; k++) begin
            bread(misc_addr[k], d);
            check("R1 misc reg reset", int'(d), 0);
        end
        for (int b = 0; b < NB; b++) begin
            bread(a_pend(b), d); check("R1 pend reset", int'(d), 0);
            bread(a_en(b), d);   check("R1 en reset", int'(d), 0);
            bread(a_mode(b), d); check("R1 mode reset", int'(d), 0);
            bread(a_pol(b), d);  check("R1 pol reset", int'(d), 0);
        end

        // R10: readback and read-only pending
        bwrite(a_en(2), 8'hA5);   bread(a_en(2), d);   check("R10 en readback", int'(d), 'hA5);
        bwrite(a_mode(1), 8'h3C); bread(a_mode(1), d); check("R10 mode readback", int'(d), 'h3C);
        bwrite(a_pol(0), 8'h81);  bread(a_pol(0), d);  check("R10 pol readback", int'(d), 'h81);
        bwrite(5'd0, 8'hFF);      bread(5'd0, d);      check("R10 cfg keeps bit4 only", int'(d), 'h10);
        bwrite(5'd0, 8'h00);
        bwrite(a_pend(0), 8'hFF); bread(a_pend(0), d); check("R10 pend write ignored", int'(d), 0);
        check("R10 irq_n after pend write", int'(irq_n), 1);
        for (int b = 0; b < NB; b++) begin
            bwrite(a_en(b), 8'h00); bwrite(a_mode(b), 8'h00); bwrite(a_pol(b), 8'h00);
        end

        // R3 / R5 / R6: edge sweep over every pin and both polarities
        for (int p = 0; p < 2; p++) begin
            gpi_in = (p == 1) ? '0 : '1;
            for (int b = 0; b < NB; b++) bwrite(a_pol(b), (p == 1) ? 8'hFF : 8'h00);
            wait_cyc(4);
            for (int pin = 0; pin < NP; pin++) begin
                for (int b = 0; b < NB; b++)
                    bwrite(a_en(b), (b == pin / 8) ? 8'(1 << (pin % 8)) : 8'h00);
                wait_cyc(2);
                clear_all_pend();
                gpi_in[pin] = (p == 1);
                wait_cyc(6);
                check("R6 irq_n low on pending", int'(irq_n), 0);
                for (int b = 0; b < NB; b++) begin
                    bread(a_pend(b), d);
                    check("R3 R5 edge pending bank", int'(d), (b == pin / 8) ? (1 << (pin % 8)) : 0);
                end
                check("R6 irq_n high after clear", int'(irq_n), 1);
                gpi_in[pin] = (p != 1);
                wait_cyc(6);
                bread(a_pend(pin / 8), d);
                check("R3 inactive edge ignored", int'(d), 0);
            end
        end
        for (int b = 0; b < NB; b++) bwrite(a_en(b), 8'h00);
        for (int b = 0; b < NB; b++) bwrite(a_pol(b), 8'h00);
        gpi_in = '1;
        wait_cyc(4);
        clear_all_pend();

        // R9: global status set, kept across pend reads, cleared by write
        bread(5'd1, d);
        check("R9 gstat set after events", int'(d), 1);
        bwrite(5'd1, 8'h01);
        bread(5'd1, d);
        check("R9 gstat cleared by write", int'(d), 0);

        // R2: pin held active before enable, edge mode
        gpi_in[5] = 1'b0;
        wait_cyc(6);
        bread(a_pend(0), d);
        check("R2 disabled pin not latched", int'(d), 0);
        bwrite(a_en(0), 8'h20);
        wait_cyc(8);
        check("R2 no irq after late enable", int'(irq_n), 1);
        bread(a_pend(0), d);
        check("R2 no pending after late enable", int'(d), 0);

        // R4 / R8: level mode with the pin still held active
        bwrite(a_mode(0), 8'h20);
        wait_cyc(3);
        check("R4 irq_n low in level mode", int'(irq_n), 0);
        bread2(a_pend(0), d, d2);
        check("R4 level pending first read", int'(d), 'h20);
        check("R8 event wins over clear", int'(d2), 'h20);
        bread(5'd1, d);
        check("R9 gstat set by level event", int'(d), 1);
        gpi_in[5] = 1'b1;
        wait_cyc(5);
        clear_all_pend();
        wait_cyc(2);
        bread(a_pend(0), d);
        check("R4 level released no pending", int'(d), 0);
        check("R4 irq_n high after release", int'(irq_n), 1);
        bwrite(5'd1, 8'h01);
        bwrite(a_mode(0), 8'h00);

        // R6 / R5: two banks pending, retrigger off
        bwrite(a_en(0), 8'h01);
        bwrite(a_en(1), 8'h02);
        wait_cyc(2);
        gpi_in[0] = 1'b0; gpi_in[9] = 1'b0;
        wait_cyc(6);
        bread(a_pend(0), d);
        check("R5 bank0 read", int'(d), 'h01);
        for (int k = 0; k < GAP + 4; k++) begin
            @(negedge clk);
            if (irq_n !== 1'b0) begin
                check("R6 irq_n held low with pending", int'(irq_n), 0);
                break;
            end
        end
        check("R6 irq_n still low", int'(irq_n), 0);
        bread(5'd1, d);
        check("R9 gstat unaffected by pend read", int'(d), 1);
        bread(a_pend(1), d);
        check("R5 bank1 kept its bit", int'(d), 'h02);
        check("R6 irq_n high when all clear", int'(irq_n), 1);

        // R7: retrigger window
        gpi_in[0] = 1'b1; gpi_in[9] = 1'b1;
        wait_cyc(5);
        clear_all_pend();
        bwrite(5'd0, 8'h10);
        gpi_in[0] = 1'b0; gpi_in[9] = 1'b0;
        wait_cyc(6);
        check("R7 irq_n low before read", int'(irq_n), 0);
        bread(a_pend(0), d);
        check("R7 bank0 read", int'(d), 'h01);
        hi = 0;
        while (irq_n === 1'b1 && hi < 4 * GAP) begin
            hi++;
            @(negedge clk);
        end
        check("R7 release window length", hi, GAP);
        check("R7 irq_n reasserted", int'(irq_n), 0);
        bread(a_pend(1), d);
        check("R7 bank1 read", int'(d), 'h02);
        check("R7 irq_n high with nothing pending", int'(irq_n), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule